// File: doc/BRIEF.md
# Level-Sensitive Three-Bank Interrupt Controller

This block collects 96 level-sensitive interrupt lines, organised as three banks of 32, and turns them into two processor requests: a normal interrupt (IRQ) and a fast interrupt (FIQ). Each line has a 6-bit priority and a route bit that sends it to one output or the other. Each bank has a mask and a software-request register. Pending state is tracked per line. A line becomes pending when its input goes high. When any input of a bank goes low, the bank's pending word is rebuilt from the inputs that are still high plus the software-request bits.

Software reaches the block through a word-addressed register port of 4 KB with a single-cycle write and a combinational read. Each output is driven by a one-shot handshake. While the handshake is armed and an eligible line exists, the output rises and the winning line number is latched. The output then stays high and the number stays frozen until software re-arms that handshake. A global gate can hold back new assertions. A soft reset returns every register to its reset value.

Top module: `lvl_intc`

## Requirements
- R1: After reset both outputs are low, every bank mask (bank window +0x04 at 0x80 + 0x20·bank) reads 0xFFFFFFFF, offset 0x00 reads 0x21, offset 0x14 reads 1, and the active numbers at 0x40 (IRQ) and 0x44 (FIQ) read 0.
- R2: A line whose input rises becomes pending at the next clock edge; when it is unmasked, IRQ-routed and the IRQ handshake is armed, irq_o rises one edge later, and bank +0x00 reads the current input levels.
- R3: When any input of a bank falls, that bank's pending word becomes (inputs still high) OR (software-request bits).
- R4: Writing bank +0x04 loads the mask, writing +0x08 clears the mask bits written as 1, writing +0x0C sets them, and reads of +0x08 and +0x0C return 0. A mask bit of 1 blocks its line.
- R5: Writing bank +0x10 ORs the value into both the software-request register (read back at +0x10) and the pending word. Writing +0x14 clears software-request bits and then sets pending to (software-request AND inputs).
- R6: Bank +0x18 reads pending AND NOT mask for lines routed to IRQ, and +0x1C reads the same for lines routed to FIQ.
- R7: The priority table holds one word per line at 0x100 + 4·line. Bits [7:2] are the priority and bit 0 routes the line to FIQ. Reads return these fields with all other bits 0.
- R8: Among eligible lines across all banks, the lowest priority value wins. On a tie, the higher line number wins. The winner's number is latched into 0x40 or 0x44 when the output rises.
- R9: An asserted output and its latched number hold until software re-arms. Re-arming writes 0x48 with bit 0 for IRQ or bit 1 for FIQ; the output drops at that write edge and is re-evaluated at the next edge. Reads of 0x40 and 0x44 have no side effect.
- R10: Writing 0x48 with bit 2 set blocks any new assertion of either output until bit 2 is written 0. Offset 0x48 reads this gate in bit 2.
- R11: Offset 0x10 bit 0 stores an idle flag that reads back in bit 0. Writing 1 to bit 1 resets every register to its reset value and drops both outputs.
- R12: Offset 0x50 stores a 2-bit idle setting. Writes to 0x4C have no effect, and 0x4C reads 0.
- R13: Accesses to the fourth bank window (0xE0 to 0xFF) are ignored and read 0. Writes to 0x00, 0x14, 0x40, 0x44 and to bank +0x00, +0x18 and +0x1C are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lines_i | input | 96 | Interrupt line levels, bit n is line n |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 12 | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Register writes take effect at the edge that samples them, and read data is combinational, so a read issued on the next low clock phase already reflects the write. A line change is seen in pending state one edge after it is driven, and in the output one edge after that. The bench therefore checks an output on the second falling edge after the stimulus, and confirms it is still low on the first. After a re-arm or a gate release, the output is low on the falling edge right after the write and takes its new value on the following falling edge. Every output check samples at these falling edges, away from the active edge.

// File: rtl/lvl_intc_pkg.sv
`timescale 1ns/1ps
package lvl_intc_pkg;

    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 12;
    localparam int LINES_PER_BANK = 32;
    localparam int BANK_CNT       = 3;
    localparam int PRIO_W         = 6;
    localparam int LINE_CNT       = BANK_CNT * LINES_PER_BANK;
    localparam int LINE_ID_W      = $clog2(LINE_CNT);
    localparam int LINE_IX_W      = $clog2(LINES_PER_BANK);
    localparam int BANK_ID_W      = LINE_ID_W - LINE_IX_W;
    localparam int WIN_LSB        = 7;   // bank windows live in the 0x80..0xFF span
    localparam int WIN_SEL_W      = 2;   // four window slots of 0x20 bytes
    localparam int PTAB_BASE_WORD = 'h100 >> 2;

    localparam logic [ADDR_W-1:0] A_REV     = 12'h000;
    localparam logic [ADDR_W-1:0] A_SYSCFG  = 12'h010;
    localparam logic [ADDR_W-1:0] A_SYSSTAT = 12'h014;
    localparam logic [ADDR_W-1:0] A_ACT_IRQ = 12'h040;
    localparam logic [ADDR_W-1:0] A_ACT_FIQ = 12'h044;
    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h048;
    localparam logic [ADDR_W-1:0] A_PROT    = 12'h04C;
    localparam logic [ADDR_W-1:0] A_IDLE    = 12'h050;

    typedef enum logic [2:0] {
        BK_RAW, BK_MASK, BK_MASK_CLR, BK_MASK_SET,
        BK_SW_SET, BK_SW_CLR, BK_PEND_IRQ, BK_PEND_FIQ
    } bank_reg_e;

    typedef struct packed {
        logic                 mask_wr;
        logic                 mask_clr;
        logic                 mask_set;
        logic                 sw_set;
        logic                 sw_clr;
        logic                 prio_wr;
        logic [LINE_IX_W-1:0] idx;
        logic [DATA_W-1:0]    data;
    } bank_cmd_t;

    function automatic logic [DATA_W-1:0] prio_word(input logic [PRIO_W-1:0] p,
                                                    input logic to_fiq);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PRIO_W+1:2] = p;
        w[0] = to_fiq;
        return w;
    endfunction

endpackage

// File: rtl/lvl_intc_bank.sv
`timescale 1ns/1ps
module lvl_intc_bank
    import lvl_intc_pkg::*;
#(
    parameter int LINES = LINES_PER_BANK,
    parameter int PW    = PRIO_W
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [LINES-1:0]          lines_i,
    input  bank_cmd_t                 cmd_i,
    output logic [LINES-1:0]          raw_o,
    output logic [LINES-1:0]          pend_o,
    output logic [LINES-1:0]          mask_o,
    output logic [LINES-1:0]          swi_o,
    output logic [LINES-1:0]          route_o,
    output logic [LINES-1:0][PW-1:0]  prio_o
);

    logic [LINES-1:0]         raw_q, pend_q, mask_q, swi_q, route_q;
    logic [LINES-1:0][PW-1:0] prio_q;
    logic [LINES-1:0]         rise, fall, pend_n, mask_n, swi_n, d;

    always_comb begin
        d      = cmd_i.data[LINES-1:0];
        rise   = lines_i & ~raw_q;
        fall   = ~lines_i & raw_q;
        // a falling line rebuilds pending from live levels and software bits
        pend_n = (|fall) ? (lines_i | swi_q) : (pend_q | rise);
        swi_n  = swi_q;
        mask_n = mask_q;
        if (cmd_i.sw_set) begin
            swi_n  = swi_q | d;
            pend_n = pend_n | d;
        end
        if (cmd_i.sw_clr) begin
            swi_n  = swi_q & ~d;
            pend_n = swi_n & lines_i;
        end
        if (cmd_i.mask_wr)  mask_n = d;
        if (cmd_i.mask_clr) mask_n = mask_q & ~d;
        if (cmd_i.mask_set) mask_n = mask_q | d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            raw_q   <= '0;
            pend_q  <= '0;
            mask_q  <= '1;
            swi_q   <= '0;
            route_q <= '0;
            prio_q  <= '0;
        end else begin
            raw_q  <= lines_i;
            pend_q <= pend_n;
            mask_q <= mask_n;
            swi_q  <= swi_n;
            if (cmd_i.prio_wr) begin
                prio_q[cmd_i.idx]  <= cmd_i.data[PW+1:2];
                route_q[cmd_i.idx] <= cmd_i.data[0];
            end
        end
    end

    assign raw_o   = raw_q;
    assign pend_o  = pend_q;
    assign mask_o  = mask_q;
    assign swi_o   = swi_q;
    assign route_o = route_q;
    assign prio_o  = prio_q;

endmodule

// File: rtl/lvl_intc_arb.sv
`timescale 1ns/1ps
module lvl_intc_arb
    import lvl_intc_pkg::*;
#(
    parameter int N  = LINE_CNT,
    parameter int PW = PRIO_W,
    parameter int IW = LINE_ID_W
) (
    input  logic [N-1:0]         req_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 hit_o,
    output logic [IW-1:0]        id_o
);

    logic [PW-1:0] best;

    // ascending scan with <= : lower value wins, equal value goes to the higher line
    always_comb begin
        best  = '0;
        hit_o = 1'b0;
        id_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!hit_o || prio_i[i] <= best)) begin
                hit_o = 1'b1;
                best  = prio_i[i];
                id_o  = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lvl_intc.sv
`timescale 1ns/1ps
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h21
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [LINE_CNT-1:0] lines_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                irq_o,
    output logic                fiq_o
);

    localparam int LPB = LINES_PER_BANK;

    // ---------------- address decode ----------------
    logic                 wr_en, win_hit, win_ok, ptab_hit, soft_rst, g_rst;
    logic [WIN_SEL_W-1:0] win_sel;
    bank_reg_e            win_reg;
    logic [ADDR_W-3:0]    word, pofs;
    logic [LINE_ID_W-1:0] pline;
    logic [BANK_ID_W-1:0] pbank;
    logic [LINE_IX_W-1:0] pidx;

    assign wr_en    = bus_sel_i & bus_wr_i;
    assign win_hit  = bus_addr_i[ADDR_W-1:WIN_LSB] == (ADDR_W-WIN_LSB)'(1);
    assign win_sel  = bus_addr_i[WIN_LSB-1 -: WIN_SEL_W];
    assign win_reg  = bank_reg_e'(bus_addr_i[WIN_LSB-WIN_SEL_W-1:2]);
    assign win_ok   = win_hit && (int'(win_sel) < BANK_CNT);
    assign word     = bus_addr_i[ADDR_W-1:2];
    assign pofs     = word - (ADDR_W-2)'(PTAB_BASE_WORD);
    assign ptab_hit = (int'(word) >= PTAB_BASE_WORD) && (int'(pofs) < LINE_CNT);
    assign pline    = pofs[LINE_ID_W-1:0];
    assign pbank    = pline[LINE_ID_W-1:LINE_IX_W];
    assign pidx     = pline[LINE_IX_W-1:0];
    assign soft_rst = wr_en && (bus_addr_i == A_SYSCFG) && bus_wdata_i[1];
    assign g_rst    = rst_i | soft_rst;

    // ---------------- banks ----------------
    bank_cmd_t                            b_cmd   [BANK_CNT];
    logic [LPB-1:0]                       b_raw   [BANK_CNT];
    logic [LPB-1:0]                       b_pend  [BANK_CNT];
    logic [LPB-1:0]                       b_mask  [BANK_CNT];
    logic [LPB-1:0]                       b_swi   [BANK_CNT];
    logic [LPB-1:0]                       b_route [BANK_CNT];
    logic [LPB-1:0][PRIO_W-1:0]           b_prio  [BANK_CNT];
    logic [LINE_CNT-1:0]                  req_irq, req_fiq;
    logic [LINE_CNT-1:0][PRIO_W-1:0]      prio_all;

    always_comb begin
        for (int b = 0; b < BANK_CNT; b++) begin
            b_cmd[b]      = '0;
            b_cmd[b].data = bus_wdata_i;
            b_cmd[b].idx  = pidx;
            if (wr_en && win_ok && int'(win_sel) == b) begin
                case (win_reg)
                    BK_MASK:     b_cmd[b].mask_wr  = 1'b1;
                    BK_MASK_CLR: b_cmd[b].mask_clr = 1'b1;
                    BK_MASK_SET: b_cmd[b].mask_set = 1'b1;
                    BK_SW_SET:   b_cmd[b].sw_set   = 1'b1;
                    BK_SW_CLR:   b_cmd[b].sw_clr   = 1'b1;
                    default:     ;
                endcase
            end
            if (wr_en && ptab_hit && int'(pbank) == b)
                b_cmd[b].prio_wr = 1'b1;
        end
    end

    for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
        lvl_intc_bank u_bank (
            .clk_i   (clk_i),
            .rst_i   (g_rst),
            .lines_i (lines_i[b*LPB +: LPB]),
            .cmd_i   (b_cmd[b]),
            .raw_o   (b_raw[b]),
            .pend_o  (b_pend[b]),
            .mask_o  (b_mask[b]),
            .swi_o   (b_swi[b]),
            .route_o (b_route[b]),
            .prio_o  (b_prio[b])
        );
        assign req_irq[b*LPB +: LPB]  = b_pend[b] & ~b_mask[b] & ~b_route[b];
        assign req_fiq[b*LPB +: LPB]  = b_pend[b] & ~b_mask[b] &  b_route[b];
        assign prio_all[b*LPB +: LPB] = b_prio[b];
    end

    // ---------------- global registers ----------------
    logic       idle_flag_q, gmask_q;
    logic [1:0] idle_cfg_q;

    always_ff @(posedge clk_i) begin
        if (g_rst) begin
            idle_flag_q <= 1'b0;
            idle_cfg_q  <= '0;
            gmask_q     <= 1'b0;
        end else if (wr_en) begin
            case (bus_addr_i)
                A_SYSCFG: idle_flag_q <= bus_wdata_i[0];
                A_IDLE:   idle_cfg_q  <= bus_wdata_i[1:0];
                A_CTRL:   gmask_q     <= bus_wdata_i[2];
                default:  ;
            endcase
        end
    end

    // ---------------- one-shot handshakes: index 0 IRQ, 1 FIQ ----------------
    logic [1:0]                 out_v;
    logic [1:0][LINE_ID_W-1:0]  act_v;

    for (genvar g = 0; g < 2; g++) begin : g_out
        logic                 hit, armed_q, out_q, rearm;
        logic [LINE_ID_W-1:0] win_id, act_q;

        lvl_intc_arb u_arb (
            .req_i  ((g == 0) ? req_irq : req_fiq),
            .prio_i (prio_all),
            .hit_o  (hit),
            .id_o   (win_id)
        );

        assign rearm = wr_en && (bus_addr_i == A_CTRL) && bus_wdata_i[g];

        always_ff @(posedge clk_i) begin
            if (g_rst) begin
                armed_q <= 1'b1;
                out_q   <= 1'b0;
                act_q   <= '0;
            end else if (rearm) begin
                armed_q <= 1'b1;
                out_q   <= 1'b0;
            end else if (armed_q && hit && !gmask_q) begin
                armed_q <= 1'b0;
                out_q   <= 1'b1;
                act_q   <= win_id;
            end
        end

        assign out_v[g] = out_q;
        assign act_v[g] = act_q;
    end

    assign irq_o = out_v[0];
    assign fiq_o = out_v[1];

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            if (win_hit) begin
                if (win_ok) begin
                    case (win_reg)
                        BK_RAW:      bus_rdata_o = b_raw[win_sel];
                        BK_MASK:     bus_rdata_o = b_mask[win_sel];
                        BK_SW_SET:   bus_rdata_o = b_swi[win_sel];
                        BK_PEND_IRQ: bus_rdata_o = b_pend[win_sel] & ~b_mask[win_sel] & ~b_route[win_sel];
                        BK_PEND_FIQ: bus_rdata_o = b_pend[win_sel] & ~b_mask[win_sel] &  b_route[win_sel];
                        default:     bus_rdata_o = '0;
                    endcase
                end
            end else if (ptab_hit) begin
                bus_rdata_o = prio_word(b_prio[pbank][pidx], b_route[pbank][pidx]);
            end else begin
                case (bus_addr_i)
                    A_REV:     bus_rdata_o = DATA_W'(REV_ID);
                    A_SYSCFG:  bus_rdata_o = DATA_W'(idle_flag_q);
                    A_SYSSTAT: bus_rdata_o = DATA_W'(1);
                    A_ACT_IRQ: bus_rdata_o = DATA_W'(act_v[0]);
                    A_ACT_FIQ: bus_rdata_o = DATA_W'(act_v[1]);
                    A_CTRL:    bus_rdata_o = DATA_W'({gmask_q, 2'b00});
                    A_PROT:    bus_rdata_o = '0;
                    A_IDLE:    bus_rdata_o = DATA_W'(idle_cfg_q);
                    default:   bus_rdata_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/lvl_intc_chk.sv
`timescale 1ns/1ps
module lvl_intc_chk
    import lvl_intc_pkg::*;
(
    input logic                       clk_i,
    input logic                       rst_i,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          bus_addr_i,
    input logic [1:0]                 ctl_bits,
    input logic                       irq_o,
    input logic                       fiq_o,
    input logic [1:0][LINE_ID_W-1:0]  act_v,
    input logic                       gmask_q
);

    logic ctl_wr, srst_wr;
    assign ctl_wr  = wr_en && (bus_addr_i == A_CTRL);
    assign srst_wr = wr_en && (bus_addr_i == A_SYSCFG) && ctl_bits[1];

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!irq_o && !fiq_o)); // R1

    AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !(ctl_wr && ctl_bits[0]) && !srst_wr) |=> irq_o); // R9

    AST_FIQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (fiq_o && !(ctl_wr && ctl_bits[1]) && !srst_wr) |=> fiq_o); // R9

    AST_ACT_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && $past(irq_o)) |-> $stable(act_v[0])); // R9

    AST_REARM_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_wr && ctl_bits[0]) |=> !irq_o); // R9

    AST_GATE_BLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        (gmask_q && !irq_o) |=> !irq_o); // R10

    AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        srst_wr |=> (!irq_o && !fiq_o)); // R11

endmodule

bind lvl_intc lvl_intc_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en      (wr_en),
    .bus_addr_i (bus_addr_i),
    .ctl_bits   (bus_wdata_i[1:0]),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .act_v      (act_v),
    .gmask_q    (gmask_q)
);

// File: tb/sim_lvl_intc.sv
`timescale 1ns/1ps
module sim_lvl_intc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] lines = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    lvl_intc u0 (
        .clk_i(clk), .rst_i(rst), .lines_i(lines),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        chk(tag, rdata, exp);
        sel = 1'b0;
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        lines[n] = v;
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 fiq", {31'd0, fiq}, 0);
        rd_chk("R1 mask b0", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R1 mask b1", 12'h0A4, 32'hFFFF_FFFF);
        rd_chk("R1 mask b2", 12'h0C4, 32'hFFFF_FFFF);
        rd_chk("R1 rev", 12'h000, 32'h21);
        rd_chk("R1 status", 12'h014, 1);
        rd_chk("R1 act irq", 12'h040, 0);
        rd_chk("R1 act fiq", 12'h044, 0);
    endtask

    task automatic t_rise();
        wr_reg(12'h088, 32'h20);
        rd_chk("R4 mask clear alias", 12'h084, 32'hFFFF_FFDF);
        set_line(5, 1'b1);
        @(negedge clk); chk("R2 irq not yet", {31'd0, irq}, 0);
        @(negedge clk); chk("R2 irq raised", {31'd0, irq}, 1);
        rd_chk("R8 act irq line5", 12'h040, 5);
        rd_chk("R9 act read twice", 12'h040, 5);
        rd_chk("R6 irq pending", 12'h098, 32'h20);
        rd_chk("R6 fiq pending", 12'h09C, 0);
        rd_chk("R2 raw inputs", 12'h080, 32'h20);
        wr_reg(12'h048, 1);
        chk("R9 rearm drops", {31'd0, irq}, 0);
        @(negedge clk); chk("R9 rearm reasserts", {31'd0, irq}, 1);
        set_line(5, 1'b0);
        rd_chk("R3 fall clears", 12'h098, 0);
        chk("R9 held after fall", {31'd0, irq}, 1);
        wr_reg(12'h048, 1);
        @(negedge clk); chk("R9 stays low", {31'd0, irq}, 0);
    endtask

    task automatic t_fall();
        wr_reg(12'h0A4, 0);
        @(negedge clk); lines[35] = 1'b1; lines[39] = 1'b1;
        wr_reg(12'h0B0, 32'h400);
        rd_chk("R5 sw set pending", 12'h0B8, 32'h488);
        rd_chk("R5 sw readback", 12'h0B0, 32'h400);
        rd_chk("R2 raw b1", 12'h0A0, 32'h88);
        set_line(35, 1'b0);
        rd_chk("R3 rebuild", 12'h0B8, 32'h480);
        wr_reg(12'h0B4, 32'h400);
        rd_chk("R5 sw cleared", 12'h0B0, 0);
        rd_chk("R5 pend = sw&in", 12'h0B8, 0);
        set_line(39, 1'b0);
        wr_reg(12'h048, 1);
        wr_reg(12'h0AC, 32'hFFFF_FFFF);
        rd_chk("R4 mask set alias", 12'h0A4, 32'hFFFF_FFFF);
        rd_chk("R4 clr alias reads 0", 12'h0A8, 0);
        rd_chk("R4 set alias reads 0", 12'h0AC, 0);
        @(negedge clk); chk("R4 irq idle", {31'd0, irq}, 0);
    endtask

    task automatic t_prio();
        wr_reg(12'h1A0, 32'hFFFF_FFFF);
        rd_chk("R7 field mask", 12'h1A0, 32'hFD);
        wr_reg(12'h1A0, 9 << 2);
        rd_chk("R7 prio readback", 12'h1A0, 32'h24);
        wr_reg(12'h218, 3 << 2);
        wr_reg(12'h108, 3 << 2);
        wr_reg(12'h088, 32'h4);
        wr_reg(12'h0A8, 32'h100);
        wr_reg(12'h0C8, 32'h40);
        @(negedge clk); lines[2] = 1'b1; lines[40] = 1'b1; lines[70] = 1'b1;
        @(negedge clk);
        @(negedge clk); chk("R8 irq", {31'd0, irq}, 1);
        rd_chk("R8 tie to higher line", 12'h040, 70);
        set_line(70, 1'b0);
        wr_reg(12'h048, 1);
        @(negedge clk); chk("R8 irq again", {31'd0, irq}, 1);
        rd_chk("R8 lower value wins", 12'h040, 2);
        wr_reg(12'h1A0, 0);
        wr_reg(12'h048, 1);
        @(negedge clk);
        rd_chk("R8 zero priority wins", 12'h040, 40);
    endtask

    task automatic t_fiq();
        wr_reg(12'h1A0, 1);
        chk("R6 fiq not yet", {31'd0, fiq}, 0);
        @(negedge clk); chk("R6 fiq raised", {31'd0, fiq}, 1);
        rd_chk("R8 act fiq", 12'h044, 40);
        rd_chk("R6 fiq pending b1", 12'h0BC, 32'h100);
        rd_chk("R6 irq pending b1", 12'h0B8, 0);
        rd_chk("R9 irq number frozen", 12'h040, 40);
        wr_reg(12'h048, 2);
        chk("R9 fiq rearm drops", {31'd0, fiq}, 0);
        chk("R9 irq unaffected", {31'd0, irq}, 1);
        @(negedge clk); chk("R9 fiq back", {31'd0, fiq}, 1);
    endtask

    task automatic t_gate();
        wr_reg(12'h048, 32'h5);
        chk("R10 irq dropped", {31'd0, irq}, 0);
        rd_chk("R10 gate readback", 12'h048, 4);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R10 irq blocked", {31'd0, irq}, 0);
        chk("R10 fiq kept", {31'd0, fiq}, 1);
        wr_reg(12'h048, 0);
        chk("R10 not yet", {31'd0, irq}, 0);
        @(negedge clk); chk("R10 released", {31'd0, irq}, 1);
        rd_chk("R10 act after release", 12'h040, 2);
    endtask

    task automatic t_sys();
        wr_reg(12'h010, 1);
        rd_chk("R11 idle flag", 12'h010, 1);
        wr_reg(12'h050, 7);
        rd_chk("R12 idle cfg", 12'h050, 3);
        wr_reg(12'h04C, 32'hFFFF_FFFF);
        rd_chk("R12 prot reads 0", 12'h04C, 0);
        rd_chk("R12 ctrl untouched", 12'h048, 0);
        wr_reg(12'h010, 2);
        chk("R11 irq low", {31'd0, irq}, 0);
        chk("R11 fiq low", {31'd0, fiq}, 0);
        rd_chk("R11 mask reset", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R11 prio reset", 12'h108, 0);
        rd_chk("R11 flag reset", 12'h010, 0);
        rd_chk("R11 idle reset", 12'h050, 0);
        rd_chk("R11 act reset", 12'h040, 0);
        @(negedge clk); chk("R11 irq masked", {31'd0, irq}, 0);
    endtask

    task automatic t_ignored();
        wr_reg(12'h0E4, 0);
        rd_chk("R13 window 3 reads 0", 12'h0E4, 0);
        rd_chk("R13 b0 mask kept", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R13 b1 mask kept", 12'h0A4, 32'hFFFF_FFFF);
        rd_chk("R13 b2 mask kept", 12'h0C4, 32'hFFFF_FFFF);
        wr_reg(12'h000, 0);
        rd_chk("R13 rev kept", 12'h000, 32'h21);
        wr_reg(12'h040, 5);
        rd_chk("R13 act kept", 12'h040, 0);
        wr_reg(12'h014, 0);
        rd_chk("R13 status kept", 12'h014, 1);
        wr_reg(12'h080, 0);
        rd_chk("R13 raw kept", 12'h080, 32'h4);
        wr_reg(12'h0B8, 32'hFFFF_FFFF);
        rd_chk("R13 pend kept", 12'h0A4, 32'hFFFF_FFFF);
        @(negedge clk); chk("R13 irq low", {31'd0, irq}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rise();
        t_fall();
        t_prio();
        t_fiq();
        t_gate();
        t_sys();
        t_ignored();
        @(negedge clk); lines = '0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule